// File: doc/BRIEF.md
# Controller Event Status Register

This block holds the event status word of a network controller. Single-cycle pulses from the transmit and receive machinery each set one sticky bit. Software reads the word and acknowledges events by writing ones to the bits it wants to clear. Two summary bits are derived from the event bits. One covers ordinary completion-type events and the other covers error and stall events. Either summary raises a level interrupt line.

A read returns the event bits, both summaries, and two live process-state fields. The fields come from the receive and transmit engines and are merged into the read data without being stored. The transmit field is forced to show a running state whenever the transmit start control is on. Bits with no function read as zero.

Top module: `evs_status_top`

## Requirements
- R1: After reset every event bit and both summaries are zero, `irq` is low, and with zero state inputs `rd_data` is zero.
- R2: A pulse on `ev_pulse[i]` sets one sticky bit, which stays set until a write clears it. Index 0..9 maps to bit positions 1, 2, 3, 5, 6, 7, 8, 9, 11, 13. Index 4 (bit 6) is receive-done.
- R3: Bit 0 (transmit done) is set only in a cycle where both `tx_done` and `tx_ioc` are high. `tx_done` without `tx_ioc` leaves bit 0 unchanged.
- R4: A cycle with `wr_en` high clears every event bit where `wr_data` holds a one and leaves every other event bit unchanged. The result is visible in the next cycle.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Bit 16 (normal summary) reads one exactly when any of bits 0, 2 or 6 is set.
- R7: Bit 15 (abnormal summary) reads one exactly when any of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R8: `irq` is high exactly when bit 15 or bit 16 reads one.
- R9: Bits 19:17 of `rd_data` equal `rx_state`. Bits 22:20 equal `tx_state` ORed with 3 when `tx_start` is high, and `tx_state` otherwise.
- R10: Bits 4, 10, 12, 14 and 31:23 always read zero. Writing ones to bits 15 and 16 neither sets nor clears a summary on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 10 | Event set pulses, one per non-transmit-done event |
| tx_done | input | 1 | Transmit frame completion pulse |
| tx_ioc | input | 1 | Completion interrupt requested for the finished frame |
| wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| wr_data | input | 32 | Status write data |
| rx_state | input | 3 | Live receive process state |
| tx_state | input | 3 | Live transmit process state |
| tx_start | input | 1 | Transmit start control bit |
| rd_data | output | 32 | Status read value |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check that the summaries agree with their event groups, that `irq` follows the summaries, and that reserved bits stay zero. Each cycle they also check that no written-one bit survives a write unless an event set it in the same cycle, and that no bit falls without a write. The bench scenarios cover the event-to-position map, the collision rule, the transmit-done gating and the full product of the state fields. These need the intended encoding, which only the stimulus supplies.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EV  = 10;
  localparam int TXI_POS = 0;
  localparam int AIS_POS = 15;
  localparam int NIS_POS = 16;

  localparam logic [DATA_W-1:0] NIS_GRP = 32'h0000_0045;
  localparam logic [DATA_W-1:0] AIS_GRP = 32'h0000_2BAA;
  localparam logic [DATA_W-1:0] EV_MASK = NIS_GRP | AIS_GRP;

  // bit position of pulse input i
  function automatic int ev_pos(input int i);
    case (i)
      0: ev_pos = 1;
      1: ev_pos = 2;
      2: ev_pos = 3;
      3: ev_pos = 5;
      4: ev_pos = 6;
      5: ev_pos = 7;
      6: ev_pos = 8;
      7: ev_pos = 9;
      8: ev_pos = 11;
      default: ev_pos = 13;
    endcase
  endfunction

  function automatic logic grp_hit(input logic [DATA_W-1:0] bits,
                                   input logic [DATA_W-1:0] grp);
    grp_hit = |(bits & grp);
  endfunction

  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    w1c_next = ((cur & ~clr) | set) & EV_MASK;
  endfunction
endpackage

// File: rtl/evs_sticky.sv
module evs_sticky
  import evs_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (EV_MASK[b]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)          q[b] <= 1'b0;
        else if (set_vec[b]) q[b] <= 1'b1;
        else if (clr_vec[b]) q[b] <= 1'b0;
      end
    end else begin : g_zero
      assign q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/evs_summary.sv
module evs_summary
  import evs_pkg::*;
(
  input  logic [DATA_W-1:0] bits,
  output logic              nis,
  output logic              ais,
  output logic              irq
);
  assign nis = grp_hit(bits, NIS_GRP);
  assign ais = grp_hit(bits, AIS_GRP);
  assign irq = nis | ais;
endmodule

// File: rtl/evs_readback.sv
module evs_readback
  import evs_pkg::*;
#(
  parameter int ST_W   = 3,
  parameter int RX_LSB = 17,
  parameter int TX_LSB = 20
) (
  input  logic [DATA_W-1:0] bits,
  input  logic              nis,
  input  logic              ais,
  input  logic [ST_W-1:0]   rx_state,
  input  logic [ST_W-1:0]   tx_state,
  input  logic              tx_start,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ST_W-1:0] RUN_CODE = ST_W'(3);

  logic [ST_W-1:0] tx_field;
  assign tx_field = tx_state | (tx_start ? RUN_CODE : '0);

  always_comb begin
    rd_data = bits & EV_MASK;
    rd_data[NIS_POS] = nis;
    rd_data[AIS_POS] = ais;
    rd_data[RX_LSB +: ST_W] = rx_state;
    rd_data[TX_LSB +: ST_W] = tx_field;
  end
endmodule

// File: rtl/evs_status_top.sv
module evs_status_top
  import evs_pkg::*;
#(
  parameter int ST_W   = 3,
  parameter int RX_LSB = 17,
  parameter int TX_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic              tx_done,
  input  logic              tx_ioc,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ST_W-1:0]   rx_state,
  input  logic [ST_W-1:0]   tx_state,
  input  logic              tx_start,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  // named internal events for the checker
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] ev_bits;
  logic              nis, ais;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_EV; i++) set_vec[ev_pos(i)] = ev_pulse[i];
    set_vec[TXI_POS] = tx_done & tx_ioc;
  end

  assign clr_vec = wr_en ? (wr_data & EV_MASK) : '0;

  evs_sticky #(.W(DATA_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(ev_bits)
  );

  evs_summary u_sum (.bits(ev_bits), .nis(nis), .ais(ais), .irq(irq));

  evs_readback #(.ST_W(ST_W), .RX_LSB(RX_LSB), .TX_LSB(TX_LSB)) u_rd (
    .bits(ev_bits), .nis(nis), .ais(ais), .rx_state(rx_state),
    .tx_state(tx_state), .tx_start(tx_start), .rd_data(rd_data)
  );
endmodule

// File: rtl/evs_status_chk.sv
module evs_status_chk
  import evs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_done,
  input logic              tx_ioc,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] clr_vec,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);
  localparam logic [DATA_W-1:0] RSVD = ~(EV_MASK | 32'h0001_8000 | 32'h007E_0000);
  logic [DATA_W-1:0] evq;
  assign evq = rd_data & EV_MASK;

  AST_NIS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[NIS_POS] == ((evq & NIS_GRP) != '0)); // R6
  AST_AIS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[AIS_POS] == ((evq & AIS_GRP) != '0)); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[NIS_POS] | rd_data[AIS_POS])); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD) == '0); // R10
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evq & $past(clr_vec & ~set_vec)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(set_vec) & EV_MASK) & ~evq) == '0)); // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evq) & ~$past(clr_vec)) & ~evq) == '0)); // R2
  AST_TXI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[TXI_POS]) |-> $past(tx_done & tx_ioc)); // R3
endmodule

bind evs_status_top evs_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_ioc(tx_ioc),
  .set_vec(set_vec), .clr_vec(clr_vec), .rd_data(rd_data), .irq(irq)
);

// File: tb/evs_status_top_bench.sv
module evs_status_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ev_pulse = '0;
  logic        tx_done = 1'b0, tx_ioc = 1'b0, wr_en = 1'b0, tx_start = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rx_state = '0, tx_state = '0;
  logic [31:0] rd_data;
  logic        irq;

  int vecs = 0, errs = 0;
  logic [31:0] model = '0;
  int pos_tab [10] = '{1, 2, 3, 5, 6, 7, 8, 9, 11, 13};

  always #10 clk = ~clk;

  evs_status_top u_evs_status_top (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .tx_done(tx_done),
    .tx_ioc(tx_ioc), .wr_en(wr_en), .wr_data(wr_data), .rx_state(rx_state),
    .tx_state(tx_state), .tx_start(tx_start), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] m);
    logic n, a;
    n = (m[0] | m[2] | m[6]);
    a = (m[1] | m[3] | m[5] | m[7] | m[8] | m[9] | m[11] | m[13]);
    return m | {15'd0, n, a, 15'd0};
  endfunction

  // one clock of stimulus, then update the model and compare
  task automatic step(input string req, input logic [9:0] ev, input logic td,
                      input logic ioc, input logic we, input logic [31:0] wd);
    logic [31:0] setm;
    setm = '0;
    for (int i = 0; i < 10; i++) if (ev[i]) setm[pos_tab[i]] = 1'b1;
    if (td && ioc) setm[0] = 1'b1;
    ev_pulse = ev; tx_done = td; tx_ioc = ioc; wr_en = we; wr_data = wd;
    @(negedge clk);
    model = (model & ~(we ? (wd & 32'h0000_2BEF) : 32'h0)) | setm;
    check(req, rd_data, expect_word(model));
    check({req, " irq"}, {31'd0, irq}, {31'd0, (expect_word(model) & 32'h0001_8000) != 0});
    ev_pulse = '0; tx_done = 1'b0; tx_ioc = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset irq", {31'd0, irq}, 32'h0);

    // R2 / R6 / R7 / R8: each event alone, then write-one clear (R4)
    for (int i = 0; i < 10; i++) begin
      step("R2 set event", 10'(1 << i), 1'b0, 1'b0, 1'b0, '0);
      step("R2 sticky hold", '0, 1'b0, 1'b0, 1'b0, '0);
      step("R4 clear other bit no effect", '0, 1'b0, 1'b0, 1'b1,
           32'h0000_2BEF & ~(32'h1 << pos_tab[i]));
      step("R4 clear own bit", '0, 1'b0, 1'b0, 1'b1, 32'h1 << pos_tab[i]);
    end

    // R3: the four combinations of done and ioc
    step("R3 done without ioc", '0, 1'b1, 1'b0, 1'b0, '0);
    step("R3 ioc without done", '0, 1'b0, 1'b1, 1'b0, '0);
    step("R3 done with ioc", '0, 1'b1, 1'b1, 1'b0, '0);
    step("R6 clear transmit done", '0, 1'b0, 1'b0, 1'b1, 32'h1);

    // R5: collision per event, each followed by a cleanup write
    for (int i = 0; i < 10; i++) begin
      step("R5 set beats clear", 10'(1 << i), 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      step("R5 cleanup", '0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    end
    step("R5 transmit done beats clear", '0, 1'b1, 1'b1, 1'b1, 32'h1);

    // R10: summary bits in write data do nothing on their own
    step("R10 summary write ignored", '0, 1'b0, 1'b0, 1'b1, 32'hFFFF_D410);
    step("R10 summary write on empty", '0, 1'b0, 1'b0, 1'b1, 32'h0001_8000);
    step("R10 clear all", '0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);

    // pseudo-random mixed sweep over events and partial clears
    begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      for (int k = 0; k < 300; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        step("R4 R5 R6 R7 mixed", lfsr[9:0] & {10{lfsr[12]}}, lfsr[13], lfsr[14],
             lfsr[15], {lfsr[7:0], lfsr[31:8]});
      end
    end
    step("R1 drain", '0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);

    // R9 exhaustive over state fields; R10 upper bits zero
    for (int s = 0; s < 128; s++) begin
      rx_state = s[2:0]; tx_state = s[5:3]; tx_start = s[6];
      #1;
      check("R9 state fields", rd_data,
            {9'd0, s[5:3] | (s[6] ? 3'd3 : 3'd0), s[2:0], 17'd0});
    end
    rx_state = '0; tx_state = '0; tx_start = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule